// File: doc/BRIEF.md
# I2C Register and Command Slave Front End

This block is the serial front end of a four-channel digital trimmer. It listens on an I2C bus, oversampling SCL and SDA from the system clock. It answers a 7-bit address built from a fixed five-bit prefix and two strap pins, so that four such devices can share one bus. After a write address, the first byte is an instruction. That byte either loads a shared register pointer, which selects the wiper registers or the nonvolatile array, or fires a quick command towards the wiper and storage logic.

Data bytes that follow a pointer load are written at the pointer, and the pointer advances after each one. A read with no instruction in front of it starts at the pointer and also advances it after each byte. A random read is an instruction write followed by a repeated START and a read. While the storage side reports a nonvolatile operation in progress, the slave refuses its own address. A master can therefore poll for completion with START plus the write address. SDA is open-drain and is modelled as an output enable.

Top module: `i2c_regcmd_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal binary 01011 followed by strap[1] and strap[0]. Bit 0 of the address byte is the direction, with 1 meaning read. Any other address is not acknowledged and produces no strobe.
- R2: In an instruction byte with bit 7 clear, bit 5 selects the array (1) or the wiper registers (0), and bits 4:0 load the pointer. After loading, reg_array and reg_addr show the new selection.
- R3: Each data byte that follows a register-mode instruction in one write transfer is acknowledged. It gives at most one reg_wr pulse, with reg_addr equal to the current pointer and reg_wdata equal to the byte, and the pointer then advances.
- R4: In wiper space the pointer advances modulo 8, with its upper bits cleared. Data at wiper pointers 4 to 7 is acknowledged but discarded, with no reg_wr pulse, and the pointer still advances.
- R5: In array space the pointer advances modulo 32, so 31 is followed by 0.
- R6: A read that has no instruction byte first returns reg_rdata at the current pointer. Each byte loaded for transmission gives one reg_rd pulse, carrying the address read, and advances the pointer under the R4 and R5 rules.
- R7: An instruction write followed by a repeated START and a read address returns data starting at the pointer that the instruction loaded.
- R8: In an instruction byte with bit 7 set, bits 6:3 are the command code, bit 2 must be 0, and bits 1:0 are the channel. A valid command gives exactly one cmd_stb pulse and leaves the pointer unchanged. Any further bytes in the same transfer are acknowledged and ignored.
- R9: Command codes 12 to 15, or any command byte with bit 2 set, are acknowledged but give no cmd_stb pulse.
- R10: While nv_busy is high when the address byte completes, the matching address is not acknowledged and no strobe occurs. Once nv_busy is low, the same address is acknowledged.
- R11: A master not-acknowledge after a read byte ends the transfer. sda_oe then stays low through any further SCL clocks until the next START.
- R12: After reset, sda_oe, reg_wr, reg_rd and cmd_stb are low, and the pointer is 0 in wiper space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (wired level) |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| strap | input | 2 | Two low address bits from board straps |
| nv_busy | input | 1 | Nonvolatile operation in progress |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle strobe: byte at reg_addr taken for transmission |
| reg_array | output | 1 | Pointer space: 1 array, 0 wiper registers |
| reg_addr | output | 5 | Shared register pointer |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rdata | input | 8 | Read data for the location at reg_array/reg_addr |
| cmd_stb | output | 1 | One-cycle quick-command strobe |
| cmd_code | output | 4 | Command code, valid with cmd_stb |
| cmd_chan | output | 2 | Channel select, valid with cmd_stb |

## Verification
The hardest state to reach from the pins is the pointer wrap after a run of discarded writes. Only a long consecutive transfer drives the wiper pointer through the reserved window 4 to 7 and back to 0. The bench therefore starts a seven-byte write at pointer 2 and checks which bytes arrive and where. It also starts an array run at 30 and reads it back across the 31-to-0 boundary through a repeated START. Acknowledge polling is reached by holding nv_busy while the matching address is shifted in, then releasing it and polling again.

// File: rtl/i2c_rc_pkg.sv
// Shared constants and types for the I2C register/command front end.
// Assumes a 5-bit register pointer and a 4-bit command code.
package i2c_rc_pkg;
    localparam int ADDR_W = 5;
    localparam int CODE_W = 4;
    localparam int CHAN_W = 2;
    localparam logic [4:0] DEV_PREFIX = 5'b01011;

    typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_state_t;
    typedef enum logic [1:0] {PH_ADDR, PH_INSTR, PH_DATA, PH_DROP} phase_t;

    typedef struct packed {
        logic              is_cmd;
        logic              cmd_ok;
        logic [CODE_W-1:0] code;
        logic [CHAN_W-1:0] chan;
        logic              sel_array;
        logic [ADDR_W-1:0] addr;
    } instr_t;
endpackage

// File: rtl/i2c_rc_sync.sv
// Brings SCL and SDA into the clock domain through a flop chain.
// Reports SCL edges, and START/STOP as SDA edges while SCL is held high.
// Assumes the system clock is many times faster than SCL and STAGES >= 2.
module i2c_rc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Shift both lines through the synchroniser and keep one extra copy for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rc_decode.sv
// Splits an instruction byte into register-access or quick-command fields.
// Purely combinational; cmd_ok is false for reserved codes or bit 2 set.
module i2c_rc_decode
    import i2c_rc_pkg::*;
#(
    parameter int CMD_LIMIT = 12
) (
    input  logic [7:0] ib,
    output instr_t     dec
);
    // Field extraction and command validity.
    always_comb begin
        dec.is_cmd    = ib[7];
        dec.code      = ib[6:3];
        dec.chan      = ib[1:0];
        dec.cmd_ok    = ib[7] & ~ib[2] & (ib[6:3] < CODE_W'(CMD_LIMIT));
        dec.sel_array = ib[5];
        dec.addr      = ib[4:0];
    end
endmodule

// File: rtl/i2c_rc_ptr.sv
// Shared register pointer with space select.
// Wiper space advances modulo 2**SPAN_W; array space uses the full width.
// wr_ok is low for wiper locations beyond the implemented channels.
module i2c_rc_ptr
    import i2c_rc_pkg::*;
#(
    parameter int SPAN_W = 3,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_array,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic              array,
    output logic              wr_ok
);
    localparam int PAD_W = ADDR_W - SPAN_W;

    logic [SPAN_W-1:0] wiper_next;
    assign wiper_next = ptr[SPAN_W-1:0] + SPAN_W'(1);

    // Load on instruction, advance after every access strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            array <= 1'b0;
        end else if (load) begin
            ptr   <= load_addr;
            array <= load_array;
        end else if (step) begin
            if (array) ptr <= ptr + ADDR_W'(1);
            else       ptr <= {{PAD_W{1'b0}}, wiper_next};
        end
    end

    assign wr_ok = array | (ptr[ADDR_W-1:CH_W] == '0);
endmodule

// File: rtl/i2c_regcmd_slave.sv
// I2C slave front end: address match, instruction decode, pointer handling,
// byte transmit/receive with acknowledge. Oversampled from clk; SDA is
// open-drain via sda_oe. Assumes no clock stretching and 7-bit addressing.
module i2c_regcmd_slave
    import i2c_rc_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int WIPER_SPAN_W = 3,
    parameter int WIPER_CH_W   = 2,
    parameter int CMD_LIMIT    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        strap,
    input  logic              nv_busy,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              reg_array,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata,
    output logic              cmd_stb,
    output logic [CODE_W-1:0] cmd_code,
    output logic [CHAN_W-1:0] cmd_chan
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    bus_state_t        st;
    phase_t            ph;
    logic [7:0]        shreg;
    logic [3:0]        bitcnt;
    logic              rd_mode;
    logic              mack_ok;
    logic              data_stb;
    logic              ld_stb;
    logic              ld_array;
    logic [ADDR_W-1:0] ld_addr;
    logic              wr_ok;
    instr_t            dec;
    logic              addr_hit;

    i2c_rc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rc_decode #(.CMD_LIMIT(CMD_LIMIT)) u_dec (
        .ib(shreg), .dec(dec)
    );

    i2c_rc_ptr #(.SPAN_W(WIPER_SPAN_W), .CH_W(WIPER_CH_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ld_stb), .load_array(ld_array),
        .load_addr(ld_addr), .step(data_stb | reg_rd),
        .ptr(reg_addr), .array(reg_array), .wr_ok(wr_ok)
    );

    assign addr_hit = (shreg[7:1] == {DEV_PREFIX, strap});
    assign reg_wr   = data_stb & wr_ok;

    // Bus protocol engine: shifts bits, places acknowledges, issues strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ph        <= PH_ADDR;
            shreg     <= '0;
            bitcnt    <= '0;
            rd_mode   <= 1'b0;
            mack_ok   <= 1'b0;
            sda_oe    <= 1'b0;
            data_stb  <= 1'b0;
            reg_rd    <= 1'b0;
            ld_stb    <= 1'b0;
            ld_array  <= 1'b0;
            ld_addr   <= '0;
            reg_wdata <= '0;
            cmd_stb   <= 1'b0;
            cmd_code  <= '0;
            cmd_chan  <= '0;
        end else begin
            data_stb <= 1'b0;
            reg_rd   <= 1'b0;
            ld_stb   <= 1'b0;
            cmd_stb  <= 1'b0;
            if (start_det) begin
                st      <= ST_RX;
                ph      <= PH_ADDR;
                bitcnt  <= '0;
                sda_oe  <= 1'b0;
                rd_mode <= 1'b0;
                mack_ok <= 1'b0;
            end else if (stop_det) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            st     <= ST_ACK;
                            sda_oe <= 1'b1;
                            case (ph)
                                PH_ADDR: begin
                                    if (!addr_hit || nv_busy) begin
                                        st     <= ST_IDLE;
                                        sda_oe <= 1'b0;
                                    end else begin
                                        rd_mode <= shreg[0];
                                        ph      <= PH_INSTR;
                                        if (shreg[0]) begin
                                            shreg  <= reg_rdata;
                                            reg_rd <= 1'b1;
                                        end
                                    end
                                end
                                PH_INSTR: begin
                                    if (dec.is_cmd) begin
                                        ph       <= PH_DROP;
                                        cmd_stb  <= dec.cmd_ok;
                                        cmd_code <= dec.code;
                                        cmd_chan <= dec.chan;
                                    end else begin
                                        ph       <= PH_DATA;
                                        ld_stb   <= 1'b1;
                                        ld_array <= dec.sel_array;
                                        ld_addr  <= dec.addr;
                                    end
                                end
                                PH_DATA: begin
                                    data_stb  <= 1'b1;
                                    reg_wdata <= shreg;
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rd_mode) begin
                                st     <= ST_TX;
                                sda_oe <= ~shreg[7];
                            end else begin
                                st     <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                st     <= ST_MACK;
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                            end else begin
                                sda_oe <= ~shreg[6];
                                shreg  <= {shreg[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (sda_s) st <= ST_IDLE;
                            else       mack_ok <= 1'b1;
                        end else if (scl_fall && mack_ok) begin
                            mack_ok <= 1'b0;
                            shreg   <= reg_rdata;
                            reg_rd  <= 1'b1;
                            sda_oe  <= ~reg_rdata[7];
                            st      <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regcmd_slave_chk.sv
// Property checker for the I2C register/command front end, bound to the top.
module i2c_regcmd_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       reg_array,
    input logic [4:0] reg_addr,
    input logic       cmd_stb,
    input logic [3:0] cmd_code
);
    // R4
    wiper_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_array) |-> (reg_addr[4:2] == 3'b000));

    // R4
    wiper_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_array) |=> (reg_addr == {2'b00, $past(reg_addr[2:0]) + 3'd1}));

    // R5
    array_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_array) |=> (reg_addr == $past(reg_addr) + 5'd1));

    // R6
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_array) |=> (reg_addr == $past(reg_addr) + 5'd1));

    // R9
    reserved_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (cmd_code < 4'd12));

    // R8
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd, cmd_stb}));
endmodule

bind i2c_regcmd_slave i2c_regcmd_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_array(reg_array), .reg_addr(reg_addr),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code)
);

// File: tb/i2c_regcmd_slave_bench.sv
module i2c_regcmd_slave_bench;
    localparam int Q = 10;
    localparam logic [7:0] AW   = 8'h5C;
    localparam logic [7:0] AR   = 8'h5D;
    localparam logic [7:0] ABAD = 8'h58;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [1:0] strap = 2'b10;
    logic       nv_busy = 1'b0;
    logic       reg_wr, reg_rd, reg_array, cmd_stb;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [3:0] cmd_code;
    logic [1:0] cmd_chan;

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, rd_cnt = 0, cmd_cnt = 0;
    logic [4:0] last_wr_addr;
    logic [7:0] last_wr_data;
    logic       last_wr_arr;
    logic [3:0] last_code;
    logic [1:0] last_chan;
    logic       watch_oe = 1'b0, oe_seen = 1'b0;
    logic       done = 1'b0;
    logic [7:0] wmem [4];
    logic [7:0] amem [32];

    always #2.5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = reg_array ? amem[reg_addr] :
                       (reg_addr < 5'd4 ? wmem[reg_addr[1:0]] : 8'hEE);

    i2c_regcmd_slave u_i2c_regcmd_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap(strap), .nv_busy(nv_busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_array(reg_array), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_chan(cmd_chan)
    );

    // Port monitor and register model of the wiper/storage side
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++)  wmem[i] = 8'h10 + 8'(i);
            for (int i = 0; i < 32; i++) amem[i] = 8'h80 + 8'(i);
        end else begin
            if (reg_wr) begin
                wr_cnt++;
                last_wr_addr = reg_addr;
                last_wr_data = reg_wdata;
                last_wr_arr  = reg_array;
                if (reg_array) amem[reg_addr] = reg_wdata;
                else           wmem[reg_addr[1:0]] = reg_wdata;
            end
            if (reg_rd) rd_cnt++;
            if (cmd_stb) begin
                cmd_cnt++;
                last_code = cmd_code;
                last_chan = cmd_chan;
            end
            if (watch_oe && sda_oe) oe_seen = 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 1'b0; wait_q();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1; wait_q(); wait_q();
            scl_m = 1'b0; wait_q();
        end
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        ack = (sda_line == 1'b0);
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl_m = 1'b1; wait_q();
            b[i] = sda_line;
            wait_q();
            scl_m = 1'b0;
        end
        wait_q();
        sda_m = ~give_ack; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        chk("R12 sda_oe", 32'(sda_oe), 0);
        chk("R12 strobes", {reg_wr, reg_rd, cmd_stb}, 0);
        chk("R12 reg_addr", 32'(reg_addr), 0);
        chk("R12 reg_array", 32'(reg_array), 0);
    endtask

    task automatic t_bad_addr();
        logic a; int w0 = wr_cnt;
        bus_start(); send_byte(ABAD, a); bus_stop();
        chk("R1 foreign address nack", 32'(a), 0);
        bus_start(); send_byte(AW, a); send_byte(8'h02, a); send_byte(8'h33, a); bus_stop();
        chk("R1 own address ack", 32'(a), 1);
        chk("R1 write count", wr_cnt - w0, 1);
    endtask

    task automatic t_single();
        logic a; int w0 = wr_cnt;
        bus_start(); send_byte(AW, a); send_byte(8'h02, a); send_byte(8'h5A, a); bus_stop();
        chk("R3 one write", wr_cnt - w0, 1);
        chk("R2 write addr", 32'(last_wr_addr), 2);
        chk("R2 wiper space", 32'(last_wr_arr), 0);
        chk("R3 write data", 32'(last_wr_data), 32'h5A);
        chk("R3 pointer advanced", 32'(reg_addr), 3);
    endtask

    task automatic t_wiper_wrap();
        logic a; int w0 = wr_cnt;
        bus_start(); send_byte(AW, a); send_byte(8'h02, a);
        for (int i = 0; i < 7; i++) send_byte(8'h21 + 8'(i), a);
        bus_stop();
        chk("R4 discarded data still acked", 32'(a), 1);
        chk("R4 writes kept", wr_cnt - w0, 3);
        chk("R4 wiper2", 32'(wmem[2]), 32'h21);
        chk("R4 wiper3", 32'(wmem[3]), 32'h22);
        chk("R4 wrap to 0", 32'(wmem[0]), 32'h27);
        chk("R4 pointer after wrap", 32'(reg_addr), 1);
    endtask

    task automatic t_array();
        logic a;
        bus_start(); send_byte(AW, a); send_byte(8'h3E, a);
        send_byte(8'hA0, a); send_byte(8'hA1, a); send_byte(8'hA2, a); bus_stop();
        chk("R5 array30", 32'(amem[30]), 32'hA0);
        chk("R5 array31", 32'(amem[31]), 32'hA1);
        chk("R5 array wrap 0", 32'(amem[0]), 32'hA2);
        chk("R5 pointer", {reg_array, reg_addr}, 32'h21);
    endtask

    task automatic t_random_read();
        logic a; logic [7:0] d0, d1;
        bus_start(); send_byte(AW, a); send_byte(8'h3E, a);
        bus_start(); send_byte(AR, a);
        chk("R7 read address ack", 32'(a), 1);
        recv_byte(1'b1, d0); recv_byte(1'b0, d1); bus_stop();
        chk("R7 first byte", 32'(d0), 32'hA0);
        chk("R7 second byte", 32'(d1), 32'hA1);
    endtask

    task automatic t_current_read();
        logic a; logic [7:0] d; int r0 = rd_cnt;
        bus_start(); send_byte(AR, a); recv_byte(1'b0, d); bus_stop();
        chk("R6 current read data", 32'(d), 32'hA2);
        chk("R6 one read strobe", rd_cnt - r0, 1);
    endtask

    task automatic t_master_nack();
        logic a; logic [7:0] d;
        bus_start(); send_byte(AR, a); recv_byte(1'b0, d);
        chk("R11 data before nack", 32'(d), 32'h81);
        oe_seen = 1'b0; watch_oe = 1'b1;
        sda_m = 1'b1;
        for (int i = 0; i < 9; i++) begin
            wait_q(); scl_m = 1'b1; wait_q(); wait_q(); scl_m = 1'b0; wait_q();
        end
        watch_oe = 1'b0;
        bus_stop();
        chk("R11 sda released after nack", 32'(oe_seen), 0);
    endtask

    task automatic t_command();
        logic a; logic [7:0] d; int c0 = cmd_cnt; int w0 = wr_cnt;
        bus_start(); send_byte(AW, a); send_byte(8'hAA, a);
        chk("R8 command ack", 32'(a), 1);
        send_byte(8'h77, a); bus_stop();
        chk("R8 third byte acked", 32'(a), 1);
        chk("R8 one command", cmd_cnt - c0, 1);
        chk("R8 code/chan", {last_code, last_chan}, {26'd0, 4'd5, 2'd2});
        chk("R8 third byte no write", wr_cnt - w0, 0);
        bus_start(); send_byte(AR, a); recv_byte(1'b0, d); bus_stop();
        chk("R8 pointer untouched", 32'(d), 32'h82);
    endtask

    task automatic t_reserved();
        logic a; int c0 = cmd_cnt;
        bus_start(); send_byte(AW, a); send_byte(8'hE9, a); bus_stop();
        chk("R9 reserved code acked", 32'(a), 1);
        chk("R9 reserved code no strobe", cmd_cnt - c0, 0);
        bus_start(); send_byte(AW, a); send_byte(8'h8C, a); bus_stop();
        chk("R9 bit2 set acked", 32'(a), 1);
        chk("R9 bit2 set no strobe", cmd_cnt - c0, 0);
    endtask

    task automatic t_busy();
        logic a; int r0 = rd_cnt;
        nv_busy = 1'b1;
        bus_start(); send_byte(AR, a); bus_stop();
        chk("R10 busy nack", 32'(a), 0);
        chk("R10 busy no strobe", rd_cnt - r0, 0);
        nv_busy = 1'b0;
        bus_start(); send_byte(AW, a); bus_stop();
        chk("R10 poll ack when idle", 32'(a), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_bad_addr();
        t_single();
        t_wiper_wrap();
        t_array();
        t_random_read();
        t_current_read();
        t_master_nack();
        t_command();
        t_reserved();
        t_busy();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule